// File: doc/BRIEF.md
# Dual-Clock Decade Up/Down Counter with Display Latch

This block counts decimal digits 0 to 9 under two separate count lines, one that steps up and one that steps down. Both lines are asynchronous to the system clock. Each one is brought into the clock domain and turned into a one-cycle event on its rising edge. The digit is stored as a five-stage twisted-ring (Johnson) code. Next-state gating sends any code outside the ten-state ring back to zero, so the counter cannot stay in an illegal state.

A display stage feeds a seven-segment decoder with active-high outputs, suitable for a common-cathode display. When the hold control is high, the decoder follows the live count. When it is low, the decoder keeps showing the last value it captured while the counter goes on counting.

Two active-low wrap outputs support cascading. Each one is normally high and drops for one clock cycle when the count wraps. A carry pulse marks an upward wrap and a borrow pulse marks a downward wrap. The pulse returns high after one cycle, so a rising edge follows every pulse. Wiring carry to the up line of the next digit, and borrow to its down line, builds a multi-digit counter with no glue logic.

Top module: `dcnt_updown_display`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0, `seg` shows digit 0 (7'h3F) and both `carry_n` and `borrow_n` are high.
- R2: Each rising edge on `count_up` adds one to the count. The new count appears in the third clock edge after the first edge at which the high level is sampled.
- R3: Each rising edge on `count_dn` subtracts one from the count, with the same latency as an up step.
- R4: If the Johnson state holds any of the 22 codes outside the ten-state ring (digit n is the n low ones for n<=5, and 5'b11111 shifted left by n-5 for n>5), the next clock edge loads digit 0.
- R5: Up and down edges detected in the same cycle leave the count unchanged. A line held at either level never blocks edges on the other line.
- R6: An up step from 9 to 0 drives `carry_n` low for exactly one cycle, in the same edge that loads 0. `carry_n` is high at all other times.
- R7: A down step from 0 to 9 drives `borrow_n` low for exactly one cycle, in the same edge that loads 9. `borrow_n` is high at all other times.
- R8: While `latch_en` is high, `seg` shows the count one clock edge after the count changes. While `latch_en` is low, `seg` keeps the last value it showed.
- R9: `seg` bit 0 is segment a through bit 6 segment g. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R10: When `carry_n` drives a second block's `count_up` and `borrow_n` drives its `count_dn`, the second block counts tens both up and down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| count_up | input | 1 | Asynchronous up-count line, acts on its rising edge |
| count_dn | input | 1 | Asynchronous down-count line, acts on its rising edge |
| latch_en | input | 1 | High: display follows the count; low: display holds |
| seg | output | 7 | Active-high segments, a in bit 0 through g in bit 6 |
| carry_n | output | 1 | Active-low one-cycle pulse on a 9 to 0 wrap |
| borrow_n | output | 1 | Active-low one-cycle pulse on a 0 to 9 wrap |

## Verification
The counter is driven in several ways, and each one isolates a different fault:
- Isolated pulses on each line check step direction and wrap detection.
- Pulses on both lines in the same cycle show whether simultaneous edges cancel or one side wins.
- Pulses one cycle apart show whether adjacent edges are lost.
- Holding one line high while the other pulses shows whether the lines are independent.

A walk through all ten digits checks the segment table. Periods with the display held check that counting and display are separate. Forcing every code outside the ring checks recovery. A second block driven by the wrap outputs checks tens counting in both directions.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int JW   = 5;
  localparam int SEGW = 7;
  localparam int MODN = 2 * JW;

  typedef logic [JW-1:0] jcode_t;

  localparam jcode_t JC_ZERO = '0;
  localparam jcode_t JC_TOP  = {1'b1, {(JW-1){1'b0}}};

  function automatic jcode_t jc_up(jcode_t c);
    return {c[JW-2:0], ~c[JW-1]};
  endfunction

  function automatic jcode_t jc_down(jcode_t c);
    return {~c[0], c[JW-1:1]};
  endfunction

  function automatic logic jc_legal(jcode_t c);
    int t;
    t = 0;
    for (int i = 0; i < JW-1; i++) if (c[i] != c[i+1]) t++;
    return (t <= 1);
  endfunction

  function automatic logic [3:0] jc_digit(jcode_t c);
    int p;
    p = $countones(c);
    if (c[JW-1]) return 4'(MODN - p);
    return 4'(p);
  endfunction
endpackage

// File: rtl/dcnt_edge_sync.sv
module dcnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= din;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dcnt_johnson.sv
module dcnt_johnson
  import dcnt_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   inc,
  input  logic   dec,
  output jcode_t state_o,
  output logic   carry_n,
  output logic   borrow_n
);
  jcode_t state_q;
  logic   carry_q, borrow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= JC_ZERO;
      carry_q  <= 1'b1;
      borrow_q <= 1'b1;
    end else begin
      carry_q  <= 1'b1;
      borrow_q <= 1'b1;
      if (!jc_legal(state_q)) begin
        state_q <= JC_ZERO;
      end else if (inc && !dec) begin
        state_q <= jc_up(state_q);
        if (state_q == JC_TOP) carry_q <= 1'b0;
      end else if (dec && !inc) begin
        state_q <= jc_down(state_q);
        if (state_q == JC_ZERO) borrow_q <= 1'b0;
      end
    end
  end

  assign state_o  = state_q;
  assign carry_n  = carry_q;
  assign borrow_n = borrow_q;
endmodule

// File: rtl/dcnt_display.sv
module dcnt_display
  import dcnt_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            latch_en,
  input  jcode_t          code,
  output logic [SEGW-1:0] seg
);
  jcode_t          held_q;
  jcode_t          sel;
  logic [SEGW-1:0] seg_d, seg_q;
  logic [3:0]      digit;

  assign sel   = latch_en ? code : held_q;
  assign digit = jc_digit(sel);

  always_comb begin
    case (digit)
      4'd0:    seg_d = 7'h3F;
      4'd1:    seg_d = 7'h06;
      4'd2:    seg_d = 7'h5B;
      4'd3:    seg_d = 7'h4F;
      4'd4:    seg_d = 7'h66;
      4'd5:    seg_d = 7'h6D;
      4'd6:    seg_d = 7'h7D;
      4'd7:    seg_d = 7'h07;
      4'd8:    seg_d = 7'h7F;
      4'd9:    seg_d = 7'h6F;
      default: seg_d = 7'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= JC_ZERO;
      seg_q  <= 7'h3F;
    end else begin
      if (latch_en) held_q <= code;
      seg_q <= seg_d;
    end
  end

  assign seg = seg_q;
endmodule

// File: rtl/dcnt_updown_display.sv
module dcnt_updown_display
  import dcnt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            count_up,
  input  logic            count_dn,
  input  logic            latch_en,
  output logic [SEGW-1:0] seg,
  output logic            carry_n,
  output logic            borrow_n
);
  logic   up_ev, dn_ev;
  jcode_t jc_state;

  dcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .din(count_up), .rise(up_ev)
  );

  dcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst(rst), .din(count_dn), .rise(dn_ev)
  );

  dcnt_johnson u_jc (
    .clk(clk), .rst(rst), .inc(up_ev), .dec(dn_ev),
    .state_o(jc_state), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  dcnt_display u_disp (
    .clk(clk), .rst(rst), .latch_en(latch_en), .code(jc_state), .seg(seg)
  );
endmodule

// File: rtl/dcnt_checker.sv
module dcnt_checker
  import dcnt_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            latch_en,
  input jcode_t          state,
  input logic            carry_n,
  input logic            borrow_n,
  input logic [SEGW-1:0] seg
);
  // R4: an off-ring code is replaced by zero at the next edge
  p_recover_r4: assert property (@(posedge clk) disable iff (rst)
    !jc_legal(state) |=> (state == JC_ZERO));

  // R6: carry low only right after a 9 to 0 step
  p_carry_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> ($past(state) == JC_TOP && state == JC_ZERO));

  // R6: carry pulse lasts one cycle
  p_carry_once_r6: assert property (@(posedge clk) disable iff (rst)
    !carry_n |=> carry_n);

  // R7: borrow low only right after a 0 to 9 step
  p_borrow_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> ($past(state) == JC_ZERO && state == JC_TOP));

  // R7: borrow pulse lasts one cycle
  p_borrow_once_r7: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |=> borrow_n);

  // R8: a held display does not change
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(seg));
endmodule

bind dcnt_updown_display dcnt_checker u_chk (
  .clk(clk), .rst(rst), .latch_en(latch_en), .state(jc_state),
  .carry_n(carry_n), .borrow_n(borrow_n), .seg(seg)
);

// File: tb/test_dcnt_updown_display.sv
`timescale 1ns/1ps
module test_dcnt_updown_display;
  logic clk = 1'b0;
  logic rst, count_up, count_dn, latch_en;
  logic [6:0] seg, seg2;
  logic carry_n, borrow_n, carry2_n, borrow2_n;
  logic [4:0] force_val;

  int checks = 0, failures = 0;
  bit done = 0, armed = 0, pause = 0;
  int carry_lows = 0, borrow_lows = 0;

  always #4 clk = ~clk;

  dcnt_updown_display i_dcnt_updown_display (
    .clk(clk), .rst(rst), .count_up(count_up), .count_dn(count_dn),
    .latch_en(latch_en), .seg(seg), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  dcnt_updown_display i_dcnt_tens (
    .clk(clk), .rst(rst), .count_up(carry_n), .count_dn(borrow_n),
    .latch_en(1'b1), .seg(seg2), .carry_n(carry2_n), .borrow_n(borrow2_n)
  );

  function automatic logic [6:0] segtab(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  function automatic logic [4:0] ring_code(int n);
    if (n <= 5) return 5'((1 << n) - 1);
    return 5'((31 << (n - 5)) & 31);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: queued input history and an integer digit
  int m_cnt, m_held;
  logic [6:0] m_seg;
  logic m_car, m_bor;
  bit uq[$], dq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_held = 0; m_seg = segtab(0); m_car = 1; m_bor = 1;
      uq = '{1, 1, 1}; dq = '{1, 1, 1};
    end else begin
      bit eu, ed;
      eu = uq[1] && !uq[0];
      ed = dq[1] && !dq[0];
      m_seg = latch_en ? segtab(m_cnt) : segtab(m_held);
      if (latch_en) m_held = m_cnt;
      m_car = 1; m_bor = 1;
      if (eu && !ed) begin
        if (m_cnt == 9) begin m_cnt = 0; m_car = 0; end else m_cnt++;
      end else if (ed && !eu) begin
        if (m_cnt == 0) begin m_cnt = 9; m_bor = 0; end else m_cnt--;
      end
      void'(uq.pop_front()); uq.push_back(count_up);
      void'(dq.pop_front()); dq.push_back(count_dn);
    end
  end

  always @(negedge clk) begin
    if (!carry_n) carry_lows++;
    if (!borrow_n) borrow_lows++;
    if (armed && !rst && !pause && !done) begin
      check(seg == m_seg, "R8 seg vs model", seg, m_seg);
      check(carry_n == m_car, "R6 carry vs model", carry_n, m_car);
      check(borrow_n == m_bor, "R7 borrow vs model", borrow_n, m_bor);
    end
  end

  task automatic settle(int n); repeat (n) @(negedge clk); endtask
  task automatic pulse_up;
    @(negedge clk) count_up = 1; settle(2); count_up = 0; settle(2);
  endtask
  task automatic pulse_dn;
    @(negedge clk) count_dn = 1; settle(2); count_dn = 0; settle(2);
  endtask
  task automatic pulse_both;
    @(negedge clk) begin count_up = 1; count_dn = 1; end
    settle(2); count_up = 0; count_dn = 0; settle(2);
  endtask
  task automatic do_reset;
    @(negedge clk) rst = 1; settle(2); rst = 0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int c0, b0;
    rst = 1; count_up = 0; count_dn = 0; latch_en = 1; force_val = '0;
    settle(3);
    check(seg == 7'h3F, "R1 reset seg", seg, 7'h3F);
    check(carry_n && borrow_n, "R1 reset wrap outputs", {carry_n, borrow_n}, 2'b11);
    rst = 0; armed = 1;

    // R2 and R6: twelve up steps through the 9 to 0 wrap
    c0 = carry_lows;
    repeat (12) pulse_up();
    settle(2);
    check(seg == segtab(2), "R2 count after 12 ups", seg, segtab(2));
    check(carry_lows - c0 == 1, "R6 one carry cycle", carry_lows - c0, 1);

    // R3 and R7: down through the 0 to 9 wrap
    b0 = borrow_lows;
    repeat (3) pulse_dn();
    settle(2);
    check(seg == segtab(9), "R3 count after 3 downs", seg, segtab(9));
    check(borrow_lows - b0 == 1, "R7 one borrow cycle", borrow_lows - b0, 1);

    // R5: simultaneous edges cancel
    repeat (2) pulse_both();
    settle(2);
    check(seg == segtab(9), "R5 simultaneous edges", seg, segtab(9));

    // R5: up held high, down keeps working
    @(negedge clk) count_up = 1;
    settle(4);
    repeat (2) pulse_dn();
    @(negedge clk) count_up = 0;
    settle(4);
    check(seg == segtab(8), "R5 up held while down pulses", seg, segtab(8));

    // R5: edges one cycle apart are both honoured
    @(negedge clk) count_up = 1;
    @(negedge clk) count_dn = 1;
    settle(2); count_up = 0; count_dn = 0; settle(4);
    check(seg == segtab(8), "R5 adjacent edges", seg, segtab(8));
    @(negedge clk) count_dn = 1;
    @(negedge clk) count_up = 1;
    settle(2); count_up = 0; count_dn = 0; settle(4);
    check(seg == segtab(8), "R5 adjacent edges reversed", seg, segtab(8));

    // R8: hold the display while counting on
    @(negedge clk) latch_en = 0;
    repeat (3) pulse_up();
    settle(2);
    check(seg == segtab(8), "R8 display held", seg, segtab(8));
    @(negedge clk) latch_en = 1;
    settle(2);
    check(seg == segtab(1), "R8 display released", seg, segtab(1));

    // R1 again mid count, then R9 digit walk
    do_reset();
    settle(1);
    check(seg == 7'h3F, "R1 reset mid count", seg, 7'h3F);
    for (int d = 0; d < 10; d++) begin
      check(seg == segtab(d), "R9 segment table", seg, segtab(d));
      pulse_up();
      settle(2);
    end

    // R4: every off-ring code recovers to zero
    do_reset();
    settle(2);
    for (int c = 0; c < 32; c++) begin
      bit on_ring;
      on_ring = 0;
      for (int n = 0; n < 10; n++) if (ring_code(n) == 5'(c)) on_ring = 1;
      if (!on_ring) begin
        pause = 1;
        @(negedge clk) begin
          force_val = 5'(c);
          force i_dcnt_updown_display.u_jc.state_q = force_val;
        end
        #1 release i_dcnt_updown_display.u_jc.state_q;
        settle(3);
        check(seg == 7'h3F, "R4 recovery from off-ring code", seg, 7'h3F);
        pause = 0;
      end
    end

    // R10: tens digit driven by wrap outputs
    do_reset();
    settle(2);
    repeat (23) pulse_up();
    settle(4);
    check(seg == segtab(3), "R10 units after 23 ups", seg, segtab(3));
    check(seg2 == segtab(2), "R10 tens after 23 ups", seg2, segtab(2));
    repeat (5) pulse_dn();
    settle(4);
    check(seg == segtab(8), "R10 units after 5 downs", seg, segtab(8));
    check(seg2 == segtab(1), "R10 tens after 5 downs", seg2, segtab(1));

    if (!done) begin
      done = 1;
      summary();
    end
  end
endmodule